// File: doc/BRIEF.md
# Vector-Quantisation Speaker Classifier

The block decides which of several enrolled speakers produced an utterance. Each speaker has a fixed codebook of 12-element codewords held in an external read-only memory. The utterance arrives as a stream of 12-element feature vectors. For every vector and every codebook, the block walks all codewords and forms the squared Euclidean distance of each codeword to the vector. It then adds the smallest of those distances to a running distortion total kept for that codebook.

When the vector marked as last has been scored, the block names the codebook with the smallest total. It also sets a reject flag if that smallest total is larger than a programmable threshold. This lets the system refuse a decision when the input is too noisy or matches nobody. Features and codebook words are signed Q16.16 numbers. Squares are taken on the full-precision difference, and every running sum saturates at its top value instead of wrapping.

Top module: `vqSpeakerClassifier`

## Requirements
- R1: While reset is held and right after it is released, `featReady` is 1 and `doneOut`, `rejectOut`, `cbRdEn` and `idOut` are 0.
- R2: A vector is taken at a rising edge where both `featValid` and `featReady` are 1. `featReady` then stays 0 until that vector has been scored. `featValid`, `featData` and `featLast` have no effect while `featReady` is 0.
- R3: While a vector is being scored, the block issues exactly NUM_BOOKS*NUM_WORDS*DIM reads with `cbRdEn`=1. The reads use the linear address book*NUM_WORDS*DIM + word*DIM + element and come in increasing order, one per cycle. The memory returns `cbRdData` one cycle after each read, and each element pair is subtracted exactly once.
- R4: For each vector, each codebook's distortion grows by the minimum, over its codewords, of the sum over the 12 elements of (feature - codeword)^2. The square is taken on the raw Q16.16 integers, with no rescaling.
- R5: Every codeword sum and every distortion total saturates at 2^ACC_W-1 and never wraps.
- R6: After the last vector, `idOut` gives the index of the codebook with the smallest distortion. On a tie, the lowest index wins.
- R7: `rejectOut` is 1 only when that smallest distortion is strictly greater than `threshold`. A minimum equal to the threshold is accepted.
- R8: `doneOut` is a one-cycle pulse. It rises NUM_BOOKS*NUM_WORDS*DIM+2 edges after the edge that takes the vector marked last. The distortion totals restart from zero with the first vector of the next utterance.
- R9: For a vector not marked last, `featReady` returns to 1 exactly NUM_BOOKS*NUM_WORDS*DIM edges after the edge that took it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featValid | input | 1 | Feature vector present |
| featReady | output | 1 | Block can take a vector |
| featLast | input | 1 | Vector closes the utterance |
| featData | input | DIM*DATA_W | Feature vector, element e at bits e*DATA_W upward, signed Q16.16 |
| threshold | input | ACC_W | Largest distortion still accepted |
| cbRdEn | output | 1 | Codebook read strobe |
| cbAddr | output | ADDR_W | Codebook word address |
| cbRdData | input | DATA_W | Codebook word, one cycle after the read |
| idOut | output | ID_W | Chosen codebook index |
| rejectOut | output | 1 | Decision refused |
| doneOut | output | 1 | Result valid for one cycle |

## Verification
Call the acceptance edge edge 0 and let N = NUM_BOOKS*NUM_WORDS*DIM. For a vector that is not last, `featReady` must still be low after edge N-1 and high after edge N. For the last vector, `doneOut` must be low after edge N+1, high with the result after edge N+2, and low again after edge N+3. The bench waits out these exact edge counts from the accepting edge and samples on the falling edge in between, so an extra or missing pipeline stage shows up as a check at the wrong value. It also counts read strobes per vector. While `featReady` is low it drives junk vectors with `featValid` high, to show they are ignored.

// File: rtl/vqPkg.sv
package vqPkg;

  typedef struct packed {
    logic loadFeat;
    logic clearDist;
    logic elemValid;
    logic elemFirst;
    logic elemLast;
    logic wordFirst;
    logic wordLast;
    logic decide;
  } vqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DECIDE
  } vqState_t;

endpackage

// File: rtl/vqControl.sv
module vqControl
  import vqPkg::*;
#(
  parameter int NUM_BOOKS = 4,
  parameter int NUM_WORDS = 128,
  parameter int DIM       = 12,
  parameter int ADDR_W    = 13,
  parameter int EIDX_W    = 4,
  parameter int BIDX_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featValid,
  input  logic              featLast,
  output logic              featReady,
  output logic              cbRdEn,
  output logic [ADDR_W-1:0] cbAddr,
  output vqStrobe_t         strb,
  output logic [EIDX_W-1:0] elemIdx,
  output logic [BIDX_W-1:0] bookIdx
);

  localparam int TOTAL  = NUM_BOOKS * NUM_WORDS * DIM;
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  vqState_t          state;
  logic [ADDR_W-1:0] addrCnt;
  logic [EIDX_W-1:0] elemCnt;
  logic [WIDX_W-1:0] wordCnt;
  logic [BIDX_W-1:0] bookCnt;
  logic              lastHeld;
  logic              newUtt;
  logic              accept;
  logic              elemEnd;
  logic              wordEnd;
  logic              sweepEnd;

  // stage-1 strobes, aligned with the memory data
  logic              s1Valid, s1First, s1Last, s1WFirst, s1WLast;
  logic [EIDX_W-1:0] s1Elem;
  logic [BIDX_W-1:0] s1Book;

  assign featReady = (state == ST_IDLE);
  assign accept    = featReady && featValid;
  assign cbRdEn    = (state == ST_RUN);
  assign cbAddr    = addrCnt;
  assign elemEnd   = (elemCnt == EIDX_W'(DIM - 1));
  assign wordEnd   = (wordCnt == WIDX_W'(NUM_WORDS - 1));
  assign sweepEnd  = (addrCnt == ADDR_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addrCnt  <= '0;
      elemCnt  <= '0;
      wordCnt  <= '0;
      bookCnt  <= '0;
      lastHeld <= 1'b0;
      newUtt   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          lastHeld <= featLast;
          newUtt   <= 1'b0;
          addrCnt  <= '0;
          elemCnt  <= '0;
          wordCnt  <= '0;
          bookCnt  <= '0;
        end
        ST_RUN: begin
          addrCnt <= addrCnt + 1'b1;
          if (elemEnd) begin
            elemCnt <= '0;
            if (wordEnd) begin
              wordCnt <= '0;
              bookCnt <= bookCnt + 1'b1;
            end else begin
              wordCnt <= wordCnt + 1'b1;
            end
          end else begin
            elemCnt <= elemCnt + 1'b1;
          end
          if (sweepEnd) state <= lastHeld ? ST_DRAIN : ST_IDLE;
        end
        ST_DRAIN: state <= ST_DECIDE;
        default: begin
          state  <= ST_IDLE;
          newUtt <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1First  <= 1'b0;
      s1Last   <= 1'b0;
      s1WFirst <= 1'b0;
      s1WLast  <= 1'b0;
      s1Elem   <= '0;
      s1Book   <= '0;
    end else begin
      s1Valid  <= cbRdEn;
      s1First  <= cbRdEn && (elemCnt == '0);
      s1Last   <= cbRdEn && elemEnd;
      s1WFirst <= cbRdEn && (wordCnt == '0);
      s1WLast  <= cbRdEn && elemEnd && wordEnd;
      s1Elem   <= elemCnt;
      s1Book   <= bookCnt;
    end
  end

  always_comb begin
    strb.loadFeat  = accept;
    strb.clearDist = accept && newUtt;
    strb.elemValid = s1Valid;
    strb.elemFirst = s1First;
    strb.elemLast  = s1Last;
    strb.wordFirst = s1WFirst;
    strb.wordLast  = s1WLast;
    strb.decide    = (state == ST_DECIDE);
  end

  assign elemIdx = s1Elem;
  assign bookIdx = s1Book;

  // R3: reads stay inside the codebook space
  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cbRdEn |-> (cbAddr < ADDR_W'(TOTAL)));

  // R3: back-to-back reads step the address by one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cbRdEn && $past(cbRdEn)) |-> (cbAddr == $past(cbAddr) + 1'b1));

  // R3: every read produces exactly one scored element next cycle
  p_one_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    cbRdEn |=> strb.elemValid);

  // R2: no vector is taken while a sweep is running
  p_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    cbRdEn |-> !featReady);

endmodule

// File: rtl/vqDatapath.sv
module vqDatapath
  import vqPkg::*;
#(
  parameter int NUM_BOOKS = 4,
  parameter int DIM       = 12,
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 64,
  parameter int ID_W      = 2,
  parameter int EIDX_W    = 4,
  parameter int BIDX_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vqStrobe_t             strb,
  input  logic [EIDX_W-1:0]     elemIdx,
  input  logic [BIDX_W-1:0]     bookIdx,
  input  logic [DIM*DATA_W-1:0] featData,
  input  logic [DATA_W-1:0]     cbRdData,
  input  logic [ACC_W-1:0]      threshold,
  output logic [ID_W-1:0]       idOut,
  output logic                  rejectOut,
  output logic                  doneOut
);

  localparam int SQ_W  = 2 * DATA_W + 2;
  localparam int SUM_W = ((SQ_W > ACC_W) ? SQ_W : ACC_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] a,
                                              input logic [SQ_W-1:0]  b);
    logic [SUM_W-1:0] t;
    t = SUM_W'(a) + SUM_W'(b);
    return (t > SUM_W'(ACC_MAX)) ? ACC_MAX : t[ACC_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] featReg [DIM];
  logic [ACC_W-1:0]         distReg [NUM_BOOKS];
  logic [ACC_W-1:0]         cwSum;
  logic [ACC_W-1:0]         bookMin;

  logic signed [DATA_W-1:0] curFeat;
  logic signed [DATA_W:0]   diff;
  logic signed [SQ_W-1:0]   prod;
  logic [ACC_W-1:0]         cwTotal;
  logic [ACC_W-1:0]         candMin;
  logic [ID_W-1:0]          bestIdx;
  logic [ACC_W-1:0]         bestVal;

  assign curFeat = featReg[elemIdx];
  assign diff    = {curFeat[DATA_W-1], curFeat} - {cbRdData[DATA_W-1], cbRdData};
  assign prod    = diff * diff;
  assign cwTotal = satAdd(strb.elemFirst ? '0 : cwSum, $unsigned(prod));
  assign candMin = (strb.wordFirst || (cwTotal < bookMin)) ? cwTotal : bookMin;

  always_ff @(posedge clk) begin
    if (strb.loadFeat) begin
      for (int e = 0; e < DIM; e++) featReg[e] <= featData[e*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwSum   <= '0;
      bookMin <= '0;
      for (int k = 0; k < NUM_BOOKS; k++) distReg[k] <= '0;
    end else begin
      if (strb.elemValid) cwSum <= cwTotal;
      if (strb.elemValid && strb.elemLast) bookMin <= candMin;
      if (strb.clearDist) begin
        for (int k = 0; k < NUM_BOOKS; k++) distReg[k] <= '0;
      end else if (strb.elemValid && strb.wordLast) begin
        distReg[bookIdx] <= satAdd(distReg[bookIdx], SQ_W'(candMin));
      end
    end
  end

  always_comb begin
    bestIdx = '0;
    bestVal = distReg[0];
    for (int k = 1; k < NUM_BOOKS; k++) begin
      if (distReg[k] < bestVal) begin
        bestIdx = ID_W'(k);
        bestVal = distReg[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idOut     <= '0;
      rejectOut <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= strb.decide;
      if (strb.decide) begin
        idOut     <= bestIdx;
        rejectOut <= (bestVal > threshold);
      end
    end
  end

  // R5: a growing codeword sum never falls back
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.elemValid && !strb.elemFirst) |=> (cwSum >= $past(cwSum)));

  // R8: the result strobe lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7: reject agrees with the chosen total and the threshold
  p_reject_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (rejectOut == (distReg[idOut] > $past(threshold))));

  for (genvar k = 0; k < NUM_BOOKS; k++) begin : g_argmin
    // R6: chosen book is no worse than any other
    p_argmin_r6: assert property (@(posedge clk) disable iff (!rstN)
      doneOut |-> (distReg[idOut] <= distReg[k]));
    // R6: lower-indexed books are strictly worse
    p_tie_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      (doneOut && (ID_W'(k) < idOut)) |-> (distReg[k] > distReg[idOut]));
  end

endmodule

// File: rtl/vqSpeakerClassifier.sv
module vqSpeakerClassifier
  import vqPkg::*;
#(
  parameter int NUM_BOOKS = 4,
  parameter int NUM_WORDS = 128,
  parameter int DIM       = 12,
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 64,
  localparam int TOTAL    = NUM_BOOKS * NUM_WORDS * DIM,
  localparam int ADDR_W   = $clog2(TOTAL),
  localparam int ID_W     = (NUM_BOOKS > 1) ? $clog2(NUM_BOOKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  featValid,
  output logic                  featReady,
  input  logic                  featLast,
  input  logic [DIM*DATA_W-1:0] featData,
  input  logic [ACC_W-1:0]      threshold,
  output logic                  cbRdEn,
  output logic [ADDR_W-1:0]     cbAddr,
  input  logic [DATA_W-1:0]     cbRdData,
  output logic [ID_W-1:0]       idOut,
  output logic                  rejectOut,
  output logic                  doneOut
);

  localparam int EIDX_W = (DIM > 1) ? $clog2(DIM) : 1;

  vqStrobe_t         strb;
  logic [EIDX_W-1:0] elemIdx;
  logic [ID_W-1:0]   bookIdx;

  vqControl #(
    .NUM_BOOKS(NUM_BOOKS), .NUM_WORDS(NUM_WORDS), .DIM(DIM),
    .ADDR_W(ADDR_W), .EIDX_W(EIDX_W), .BIDX_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .featValid(featValid), .featLast(featLast),
    .featReady(featReady), .cbRdEn(cbRdEn), .cbAddr(cbAddr),
    .strb(strb), .elemIdx(elemIdx), .bookIdx(bookIdx)
  );

  vqDatapath #(
    .NUM_BOOKS(NUM_BOOKS), .DIM(DIM), .DATA_W(DATA_W), .ACC_W(ACC_W),
    .ID_W(ID_W), .EIDX_W(EIDX_W), .BIDX_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .elemIdx(elemIdx), .bookIdx(bookIdx),
    .featData(featData), .cbRdData(cbRdData), .threshold(threshold),
    .idOut(idOut), .rejectOut(rejectOut), .doneOut(doneOut)
  );

endmodule

// File: tb/vqSpeakerClassifier_tb.sv
module vqSpeakerClassifier_tb;

  localparam int NB  = 4;
  localparam int NW  = 128;
  localparam int DIM = 12;
  localparam int DW  = 32;
  localparam int AW  = 64;
  localparam int N   = NB * NW * DIM;
  localparam int ADW = $clog2(N);
  localparam logic [AW-1:0] AMAX = {AW{1'b1}};

  // mode 0: hashed books, book `target` holds the features as codewords
  // mode 1: extreme values that saturate every sum
  // mode 2: all books identical (tie)
  typedef struct packed {
    logic [1:0]    mode;
    logic [7:0]    seed;
    logic [2:0]    target;
    logic [2:0]    nVec;
    logic [2:0]    expId;   // 7 = no fixed expectation
    logic [AW-1:0] thr;
  } entry_t;

  localparam entry_t TBL [7] = '{
    '{2'd0, 8'd1, 3'd2, 3'd2, 3'd2, 64'd0},
    '{2'd0, 8'd2, 3'd4, 3'd3, 3'd7, 64'd1},
    '{2'd0, 8'd3, 3'd1, 3'd1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd0, 8'd5, 3'd3, 3'd2, 3'd3, 64'd5},
    '{2'd2, 8'd7, 3'd4, 3'd2, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd1, 8'd0, 3'd4, 3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd1, 8'd0, 3'd4, 3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFE}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                featValid = 1'b0;
  logic                featReady;
  logic                featLast = 1'b0;
  logic [DIM*DW-1:0]   featData = '0;
  logic [AW-1:0]       threshold = '0;
  logic                cbRdEn;
  logic [ADW-1:0]      cbAddr;
  logic [DW-1:0]       cbRdData = '0;
  logic [1:0]          idOut;
  logic                rejectOut;
  logic                doneOut;

  int errCnt = 0;
  int chkCnt = 0;
  int rdCount = 0;
  int curMode = 0, curSeed = 0, curTarget = 0;
  logic [AW-1:0] mdlDist [NB];
  logic [1:0]    gotId;
  logic          gotRej;

  always #10 clk = ~clk;

  vqSpeakerClassifier u_dut (
    .clk(clk), .rstN(rstN), .featValid(featValid), .featReady(featReady),
    .featLast(featLast), .featData(featData), .threshold(threshold),
    .cbRdEn(cbRdEn), .cbAddr(cbAddr), .cbRdData(cbRdData),
    .idOut(idOut), .rejectOut(rejectOut), .doneOut(doneOut)
  );

  function automatic logic [DW-1:0] mix(input int a, input int b, input int c, input int d);
    logic [31:0] h;
    h = (32'(a) * 32'd73856093) ^ (32'(b) * 32'd19349663) ^
        (32'(c) * 32'd83492791) ^ (32'(d) * 32'd2654435761);
    h = h ^ (h >> 13);
    h = h * 32'd1274126177;
    return $unsigned($signed(h) >>> 10);
  endfunction

  function automatic logic [DW-1:0] featWord(input int v, input int e);
    if (curMode == 1) return 32'h7FFF_FFFF;
    return mix(curSeed, 100 + v, e, 9);
  endfunction

  function automatic logic [DW-1:0] cbWord(input int b, input int w, input int e);
    if (curMode == 1) return 32'h8000_0000;
    if (curMode == 2) return mix(curSeed, 0, w, e);
    if (b == curTarget && w < 8) return featWord(w, e);
    return mix(curSeed, b + 1, w, e);
  endfunction

  always @(posedge clk) begin
    if (cbRdEn) begin
      cbRdData <= cbWord(int'(cbAddr) / (NW * DIM), (int'(cbAddr) % (NW * DIM)) / DIM,
                         int'(cbAddr) % DIM);
      rdCount  <= rdCount + 1;
    end
  end

  function automatic logic [AW-1:0] sat(input logic [AW-1:0] a, input logic [2*DW+1:0] b);
    logic [2*DW+2:0] t;
    t = (2*DW+3)'(a) + (2*DW+3)'(b);
    return (t > (2*DW+3)'(AMAX)) ? AMAX : t[AW-1:0];
  endfunction

  task automatic modelVec(input int v);
    for (int b = 0; b < NB; b++) begin
      logic [AW-1:0] best;
      best = AMAX;
      for (int w = 0; w < NW; w++) begin
        logic [AW-1:0] s;
        s = '0;
        for (int e = 0; e < DIM; e++) begin
          logic signed [DW:0]     d;
          logic signed [2*DW+1:0] p;
          d = $signed({featWord(v, e)[DW-1], featWord(v, e)}) -
              $signed({cbWord(b, w, e)[DW-1], cbWord(b, w, e)});
          p = d * d;
          s = sat(s, $unsigned(p));
        end
        if (s < best) best = s;
      end
      mdlDist[b] = sat(mdlDist[b], (2*DW+2)'(best));
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendVec(input int v, input bit last);
    @(negedge clk);
    for (int e = 0; e < DIM; e++) featData[e*DW +: DW] = featWord(v, e);
    featLast  = last;
    featValid = 1'b1;
    while (!featReady) @(negedge clk);
    @(posedge clk);                // acceptance edge 0
    @(negedge clk);
    rdCount  = 0;
    featData = ~featData;          // junk while busy (R2)
    featLast = ~last;
    repeat (N - 1) @(negedge clk);
    featValid = 1'b0;
    check(featReady == 1'b0, "R2 busy", 64'(featReady), 0);
    if (!last) begin
      @(negedge clk);
      check(featReady == 1'b1, "R9 ready return", 64'(featReady), 1);
      check(rdCount == N, "R3 read count", 64'(rdCount), 64'(N));
    end else begin
      repeat (2) @(negedge clk);
      check(doneOut == 1'b0, "R8 done early", 64'(doneOut), 0);
      @(negedge clk);
      check(doneOut == 1'b1, "R8 done due", 64'(doneOut), 1);
      check(rdCount == N, "R3 read count", 64'(rdCount), 64'(N));
      gotId  = idOut;
      gotRej = rejectOut;
      @(negedge clk);
      check(doneOut == 1'b0, "R8 done pulse", 64'(doneOut), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(featReady && !doneOut && !rejectOut && !cbRdEn && idOut == 0, "R1 in reset",
          {59'd0, featReady, doneOut, rejectOut, cbRdEn, |idOut}, 64'h10);
    rstN = 1'b1;
    @(negedge clk);
    check(featReady && !doneOut && !rejectOut && !cbRdEn && idOut == 0, "R1 after reset",
          {59'd0, featReady, doneOut, rejectOut, cbRdEn, |idOut}, 64'h10);

    for (int t = 0; t < 7; t++) begin
      logic [1:0]    expId;
      logic [AW-1:0] expMin;
      curMode   = int'(TBL[t].mode);
      curSeed   = int'(TBL[t].seed);
      curTarget = int'(TBL[t].target);
      threshold = TBL[t].thr;
      for (int b = 0; b < NB; b++) mdlDist[b] = '0;
      for (int v = 0; v < int'(TBL[t].nVec); v++) begin
        modelVec(v);
        sendVec(v, v == int'(TBL[t].nVec) - 1);
      end
      expId  = 2'd0;
      expMin = mdlDist[0];
      for (int b = 1; b < NB; b++)
        if (mdlDist[b] < expMin) begin expId = 2'(b); expMin = mdlDist[b]; end
      check(gotId == expId, "R4 R6 identity", 64'(gotId), 64'(expId));
      if (TBL[t].expId != 3'd7)
        check(gotId == TBL[t].expId[1:0], "R6 table id", 64'(gotId), 64'(TBL[t].expId));
      check(gotRej == (expMin > TBL[t].thr), "R7 reject", 64'(gotRej),
            64'(expMin > TBL[t].thr));
      if (curMode == 1)
        check(expMin == AMAX, "R5 saturation model", expMin, AMAX);
    end

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule